// File: doc/BRIEF.md
# PAL-style combinatorial output macrocell array

This block is a small programmable-logic fabric in its combinatorial configuration. An AND array forms product terms from two dedicated data inputs and from the pin values of six bidirectional macrocells. Each of eight output macrocells uses one product term as its output enable and ORs the remaining terms. It then applies a programmable polarity and drives a pin. A driven pin is shown as `pin_oe` high with its value on `pin_out`. A pin with `pin_oe` low is high-impedance, and the value on that pin is supplied by the surrounding pad logic through `pad_in`.

The whole personality arrives as one static vector, `fuse_map`. It holds the product-term masks, one polarity bit per macrocell and three mode bits. Evaluation is registered. On each rising clock edge with power-down low, every macrocell takes a new value computed from the current inputs and from the pin values of the previous evaluation. Registering the evaluation keeps the feedback paths free of combinational loops. While power-down is high, the array holds its state.

All ports are plain level signals sampled by the clock. No data is transferred in packets, so the block has no valid/ready handshake and no back-pressure.

Top module: `pal_macro_array`

## Requirements
- R1: While `rst_n` is low, every macrocell is reset: `pin_out` is all zeros and `pin_oe` is all zeros.
- R2: Each product term has two mask bits for each array signal s. For term t of macrocell m, the bits sit at `fuse_map[(m*N_PT+t)*2*N_SIG + 2*s +: 2]`. Code 00 ignores the signal, 01 includes its true form, 10 includes its complement, and 11 forces the term to 0. A term that includes no signal evaluates to 1.
- R3: Term 0 of each macrocell is its output enable. Terms 1 to N_PT-1 are ORed to form the sum. `pin_oe[m]` follows term 0 with a latency of one evaluation.
- R4: The polarity bit of macrocell m sits at `fuse_map[N_MC*N_PT*2*N_SIG + m]`. A value of 1 drives the sum unchanged and a value of 0 drives the inverted sum.
- R5: Array signals s0 and s1 are `ded_in[0]` and `ded_in[1]`. Signals s2 to s7 are the pin values of macrocells 1 to 6. Macrocells 0 and 7 are output-only and feed nothing back into the array.
- R6: The pin value fed back for macrocell k (1..6) is `pin_out[k]` when `pin_oe[k]` is high and `pad_in[k-1]` otherwise.
- R7: The SYN bit is at mode offset 0 and the AC0 bit is at mode offset 1, where the mode offset base is `N_MC*N_PT*2*N_SIG + N_MC`. If either bit is 0, `cfg_err` goes high in the same cycle and all of `pin_oe` goes low.
- R8: The AC1 bit at mode offset 2 has no effect on any output.
- R9: While `pd` is high at a rising edge, `pin_out` and the internal enables keep their values. The first edge with `pd` low updates them again.
- R10: With `pd` low, each rising edge loads every macrocell from the current inputs and from the previous pin values. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Power-down: holds all macrocells, never an array input |
| fuse_map | input | N_MC*N_PT*2*N_SIG+N_MC+3 | Static configuration: masks, polarity bits, mode bits |
| ded_in | input | N_DED | Dedicated data inputs to the AND array |
| pad_in | input | N_MC-2 | Externally driven values of pins of macrocells 1..6 |
| pin_out | output | N_MC | Value driven by each macrocell |
| pin_oe | output | N_MC | Drive enable per macrocell; low means high-impedance |
| cfg_err | output | 1 | Mode bits do not select the combinatorial configuration |

## Verification
The bench uses the default parameters: two dedicated inputs, eight macrocells and eight product terms per macrocell. With these values the whole array has eight signals, and each fuse-field offset named in the requirements is a fixed number that the bench can address directly. At this size, random personalities with a bias towards ignored signals regularly give terms that fire. Those terms reach the feedback-through-tri-state path, the both-forms term, the power-down hold and the invalid-mode gating.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Per-signal selection code inside a product-term mask
  typedef enum logic [1:0] {
    SEL_IGNORE = 2'b00,
    SEL_TRUE   = 2'b01,
    SEL_COMP   = 2'b10,
    SEL_NEVER  = 2'b11
  } sel_t;

  // Architecture selected by the mode bits
  typedef enum logic [1:0] {
    MODE_REGISTERED = 2'b00,
    MODE_SIMPLE     = 2'b01,
    MODE_COMBO      = 2'b10
  } arch_t;

endpackage

// File: rtl/pal_term.sv
module pal_term
  import pal_pkg::*;
#(
  parameter int N_SIG = 8,
  localparam int MASK_W = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]  sig,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);

  always_comb begin
    hit = 1'b1;
    for (int s = 0; s < N_SIG; s++) begin
      case (sel_t'(mask[2*s +: 2]))
        SEL_TRUE:  hit = hit & sig[s];
        SEL_COMP:  hit = hit & ~sig[s];
        SEL_NEVER: hit = 1'b0;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_SIG = 8,
  parameter int N_PT  = 8,
  localparam int MASK_W = 2 * N_SIG,
  localparam int CELL_W = N_PT * MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [N_SIG-1:0]  sig,
  input  logic [CELL_W-1:0] masks,
  input  logic              pol,
  output logic              out_q,
  output logic              oe_q
);

  logic [N_PT-1:0] terms;
  logic            sum;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    pal_term #(.N_SIG(N_SIG)) u_term (
      .sig  (sig),
      .mask (masks[t*MASK_W +: MASK_W]),
      .hit  (terms[t])
    );
  end

  // term 0 is the enable; the rest form the sum
  assign sum = |terms[N_PT-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (eval_en) begin
      out_q <= pol ? sum : ~sum;
      oe_q  <= terms[0];
    end
  end

endmodule

// File: rtl/pal_mode_check.sv
module pal_mode_check
  import pal_pkg::*;
(
  input  logic syn,
  input  logic ac0,
  input  logic ac1,
  output logic cfg_err
);

  arch_t arch;

  always_comb begin
    case ({syn, ac0, ac1})
      3'b110, 3'b111: arch = MODE_COMBO;
      3'b100, 3'b101: arch = MODE_SIMPLE;
      default:        arch = MODE_REGISTERED;
    endcase
  end

  assign cfg_err = (arch != MODE_COMBO);

endmodule

// File: rtl/pal_macro_array.sv
module pal_macro_array #(
  parameter int N_DED = 2,
  parameter int N_MC  = 8,
  parameter int N_PT  = 8,
  localparam int N_FB    = N_MC - 2,
  localparam int N_SIG   = N_DED + N_FB,
  localparam int MASK_W  = 2 * N_SIG,
  localparam int CELL_W  = N_PT * MASK_W,
  localparam int POL_LSB = N_MC * CELL_W,
  localparam int MODE_LSB = POL_LSB + N_MC,
  localparam int FUSE_W  = MODE_LSB + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic [FUSE_W-1:0] fuse_map,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_FB-1:0]   pad_in,
  output logic [N_MC-1:0]   pin_out,
  output logic [N_MC-1:0]   pin_oe,
  output logic              cfg_err
);

  logic [N_MC-1:0]  out_q;
  logic [N_MC-1:0]  oe_q;
  logic [N_FB-1:0]  fb;
  logic [N_SIG-1:0] sig;

  pal_mode_check u_mode (
    .syn     (fuse_map[MODE_LSB]),
    .ac0     (fuse_map[MODE_LSB+1]),
    .ac1     (fuse_map[MODE_LSB+2]),
    .cfg_err (cfg_err)
  );

  assign pin_out = out_q;
  assign pin_oe  = oe_q & {N_MC{~cfg_err}};

  // inner macrocells see their own pin; outer ones have no path back
  for (genvar i = 0; i < N_FB; i++) begin : g_fb
    assign fb[i] = pin_oe[i+1] ? out_q[i+1] : pad_in[i];
  end

  assign sig = {fb, ded_in};

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    pal_macrocell #(.N_SIG(N_SIG), .N_PT(N_PT)) u_mc (
      .clk     (clk),
      .rst_n   (rst_n),
      .eval_en (~pd),
      .sig     (sig),
      .masks   (fuse_map[m*CELL_W +: CELL_W]),
      .pol     (fuse_map[POL_LSB+m]),
      .out_q   (out_q[m]),
      .oe_q    (oe_q[m])
    );
  end

endmodule

// File: rtl/pal_macro_array_chk.sv
module pal_macro_array_chk #(
  parameter int N_MC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd,
  input logic            cfg_err,
  input logic [N_MC-1:0] pin_out,
  input logic [N_MC-1:0] pin_oe,
  input logic [N_MC-1:0] oe_q
);

  a_r7_err_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (pin_oe == '0));

  a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(pin_out));

  a_r9_hold_oe: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(oe_q));

  a_r1_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

endmodule

bind pal_macro_array pal_macro_array_chk #(.N_MC(N_MC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pd      (pd),
  .cfg_err (cfg_err),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .oe_q    (oe_q)
);

// File: tb/sim_pal_macro_array.sv
`timescale 1ns/1ps
module sim_pal_macro_array;

  localparam int NDED = 2;
  localparam int NMC  = 8;
  localparam int NPT  = 8;
  localparam int NFB  = NMC - 2;
  localparam int NSIG = NDED + NFB;
  localparam int MW   = 2 * NSIG;
  localparam int TB   = NMC * NPT * MW;
  localparam int MB   = TB + NMC;
  localparam int FW   = MB + 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pd = 1'b0;
  logic [FW-1:0]   fz;
  logic [NDED-1:0] ded;
  logic [NFB-1:0]  pad;
  logic [NMC-1:0]  pin_out, pin_oe;
  logic            cfg_err;

  logic [NMC-1:0]  m_out, m_oe;
  int              n_chk = 0, n_fail = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  pal_macro_array u0 (
    .clk(clk), .rst_n(rst_n), .pd(pd), .fuse_map(fz),
    .ded_in(ded), .pad_in(pad),
    .pin_out(pin_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [NMC-1:0] got, input logic [NMC-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic logic term_m(input logic [MW-1:0] mk, input logic [NSIG-1:0] sg);
    logic h = 1'b1;
    for (int s = 0; s < NSIG; s++) begin
      if (mk[2*s +: 2] == 2'b01) h = h & sg[s];
      else if (mk[2*s +: 2] == 2'b10) h = h & ~sg[s];
      else if (mk[2*s +: 2] == 2'b11) h = 1'b0;
    end
    return h;
  endfunction

  function automatic logic [MW-1:0] one_sig(input int s, input logic [1:0] c);
    logic [MW-1:0] r = '0;
    r[2*s +: 2] = c;
    return r;
  endfunction

  task automatic set_term(input int m, input int t, input logic [MW-1:0] mk);
    fz[(m*NPT+t)*MW +: MW] = mk;
  endtask

  function automatic logic mode_ok();
    return fz[MB] & fz[MB+1];
  endfunction

  // one evaluation: model next state from current inputs, then compare
  task automatic tick(input string tag);
    logic [NMC-1:0]  n_out, n_oe, p_oe;
    logic [NFB-1:0]  fb;
    logic [NSIG-1:0] sg;
    logic            sum;
    p_oe = m_oe & {NMC{mode_ok()}};
    for (int i = 0; i < NFB; i++) fb[i] = p_oe[i+1] ? m_out[i+1] : pad[i];
    sg = {fb, ded};
    for (int m = 0; m < NMC; m++) begin
      n_oe[m] = term_m(fz[(m*NPT)*MW +: MW], sg);
      sum = 1'b0;
      for (int t = 1; t < NPT; t++) sum = sum | term_m(fz[(m*NPT+t)*MW +: MW], sg);
      n_out[m] = fz[TB+m] ? sum : ~sum;
    end
    if (pd) begin
      n_out = m_out;
      n_oe  = m_oe;
    end
    @(posedge clk);
    @(negedge clk);
    m_out = n_out;
    m_oe  = n_oe;
    chk(tag, "pin_out", pin_out, m_out);
    chk(tag, "pin_oe", pin_oe, m_oe & {NMC{mode_ok()}});
    chk(tag, "cfg_err", {7'b0, cfg_err}, {7'b0, ~mode_ok()});
  endtask

  function automatic logic [FW-1:0] rnd_fuse();
    logic [FW-1:0] f = '0;
    int r;
    for (int m = 0; m < NMC; m++)
      for (int t = 0; t < NPT; t++)
        for (int s = 0; s < NSIG; s++) begin
          r = $urandom % 32;
          if (t == 0 && ($urandom % 2) == 0) r = 0;
          f[(m*NPT+t)*MW + 2*s +: 2] = (r < 24) ? 2'b00 : (r < 28) ? 2'b01 :
                                       (r < 31) ? 2'b10 : 2'b11;
        end
    for (int m = 0; m < NMC; m++) f[TB+m] = 1'($urandom % 2);
    f[MB]   = (($urandom % 10) != 0);
    f[MB+1] = (($urandom % 10) != 0);
    f[MB+2] = 1'($urandom % 2);
    return f;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got %0d exp 0", 1);
    finish_up();
  end

  initial begin
    logic [NMC-1:0] saved;
    void'($urandom(32'd4711));
    fz = '0;
    for (int m = 0; m < NMC; m++) fz[TB+m] = 1'b1;
    fz[MB] = 1'b1;
    fz[MB+1] = 1'b1;
    ded = '0;
    pad = '0;
    m_out = '0;
    m_oe = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pin_out in reset", pin_out, 8'h00);
    chk("R1", "pin_oe in reset", pin_oe, 8'h00);
    rst_n = 1'b1;

    // R2: all-ignore terms are 1, so every pin drives 1
    tick("R2");
    chk("R2", "empty terms out", pin_out, 8'hff);
    chk("R3", "empty enable", pin_oe, 8'hff);

    // R4: polarity 0 inverts
    for (int m = 0; m < NMC; m++) fz[TB+m] = 1'b0;
    tick("R4");
    chk("R4", "inverted out", pin_out, 8'h00);
    for (int m = 0; m < NMC; m++) fz[TB+m] = 1'b1;
    tick("R4");

    // R2: both forms of one signal kill a term
    for (int t = 1; t < NPT; t++) set_term(2, t, one_sig(0, 2'b11));
    tick("R2");
    chk("R2", "both-forms out2", {7'b0, pin_out[2]}, 8'h00);

    // R3: enable term 0 for macrocell 1
    set_term(1, 0, one_sig(1, 2'b11));
    tick("R3");
    chk("R3", "oe1 off", {7'b0, pin_oe[1]}, 8'h00);

    // R6: macrocell 0 sum = s2 true (pin of macrocell 1)
    set_term(0, 1, one_sig(2, 2'b01));
    for (int t = 2; t < NPT; t++) set_term(0, t, one_sig(0, 2'b11));
    pad = 6'b000001;
    tick("R6");
    chk("R6", "pad feeds back", {7'b0, pin_out[0]}, 8'h01);
    pad = 6'b000000;
    tick("R6");
    chk("R6", "pad low feeds back", {7'b0, pin_out[0]}, 8'h00);
    set_term(1, 0, '0);
    tick("R6");
    tick("R6");
    chk("R6", "driven pin overrides pad", {7'b0, pin_out[0]}, 8'h01);

    // R5: macrocell 4 sum = complement of ded_in[0]
    set_term(4, 1, one_sig(0, 2'b10));
    for (int t = 2; t < NPT; t++) set_term(4, t, one_sig(0, 2'b11));
    ded = 2'b00;
    tick("R5");
    chk("R5", "ded0 low", {7'b0, pin_out[4]}, 8'h01);
    ded = 2'b01;
    tick("R5");
    chk("R5", "ded0 high", {7'b0, pin_out[4]}, 8'h00);
    // R5: macrocell 3 follows s7 = pin of macrocell 6
    set_term(3, 1, one_sig(7, 2'b10));
    for (int t = 2; t < NPT; t++) set_term(3, t, one_sig(0, 2'b11));
    tick("R5");
    tick("R5");

    // R7: invalid mode bits
    fz[MB] = 1'b0;
    #1;
    chk("R7", "syn=0 cfg_err", {7'b0, cfg_err}, 8'h01);
    chk("R7", "syn=0 pin_oe", pin_oe, 8'h00);
    tick("R7");
    fz[MB] = 1'b1;
    fz[MB+1] = 1'b0;
    #1;
    chk("R7", "ac0=0 cfg_err", {7'b0, cfg_err}, 8'h01);
    chk("R7", "ac0=0 pin_oe", pin_oe, 8'h00);
    tick("R7");
    fz[MB+1] = 1'b1;
    tick("R7");
    tick("R7");

    // R8: AC1 ignored
    saved = pin_out;
    fz[MB+2] = ~fz[MB+2];
    tick("R8");
    chk("R8", "ac1 toggled out", pin_out, saved);
    chk("R8", "ac1 cfg_err", {7'b0, cfg_err}, 8'h00);

    // R9: power-down holds
    saved = pin_out;
    pd = 1'b1;
    ded = ~ded;
    pad = ~pad;
    for (int m = 0; m < NMC; m++) fz[TB+m] = ~fz[TB+m];
    repeat (3) begin
      tick("R9");
      chk("R9", "held out", pin_out, saved);
    end
    pd = 1'b0;
    tick("R9");

    // R10: random personalities and inputs
    for (int n = 0; n < 3000; n++) begin
      if (n % 50 == 0) fz = rnd_fuse();
      ded = NDED'($urandom);
      pad = NFB'($urandom);
      pd  = (($urandom % 8) == 0);
      tick("R10");
    end
    pd = 1'b0;
    finish_up();
  end

endmodule